// File: doc/BRIEF.md
# Set-Associative Translation Cache with Access-Rights Check

This block holds recently used page table entries so that a virtual page number can be turned into a physical page number without a memory access. A requester presents a virtual page number together with the kind of access (load, store or instruction fetch) and whether it runs in user mode. In the same cycle the block answers with a hit flag, the physical page number and a protection-fault flag. Every stored entry carries four rights bits: supervisor-only, readable, writable and executable. These bits are checked on every lookup that matches a line.

On a miss the surrounding logic walks the page table itself. It then writes the result in through the fill port, and the entry can be used from the next clock edge on. A flush input empties the whole structure in one cycle. The default geometry is 16 sets of 4 ways, a 20-bit virtual page number and a 16-bit physical page number.

Top module: `tlb_xlate`

## Requirements
- R1: The low 4 bits of `lk_vpn` (and of `fl_vpn`) select one of 16 sets, and the upper 16 bits form the tag. A lookup matches when a valid way of the selected set holds an equal tag.
- R2: On a permitted match `lk_hit` is 1 and `lk_ppn` is the stored physical page number. On a miss `lk_hit`, `lk_fault` and `lk_ppn` are all 0.
- R3: `lk_acc` codes are 0 = load (needs readable), 1 = store (needs writable), 2 = fetch (needs executable) and 3 = reserved (never permitted). A match faults when the needed right is 0, or when `lk_user` is 1 and the supervisor-only bit is 1. On a fault `lk_fault` is 1, while `lk_hit` and `lk_ppn` are 0.
- R4: A fill whose tag is not present in its set writes the lowest-numbered invalid way of that set.
- R5: When all four ways of the set are valid and the tag is absent, a fill replaces the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one, modulo 4, only on such a replacement.
- R6: A fill whose tag is already present in its set overwrites that way. It leaves the other ways and the pointer untouched, so one tag never occupies two ways.
- R7: `flush` invalidates every line at the next clock edge. A fill presented in the same cycle as `flush` is dropped.
- R8: A lookup is answered combinationally from the state at the start of the cycle. A fill becomes visible to lookups only after the next rising edge.
- R9: While `lk_valid` is 0, `lk_hit`, `lk_fault` and `lk_ppn` are 0.
- R10: After reset every line is invalid and every round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_user | input | 1 | 1 = user-mode access |
| lk_hit | output | 1 | Permitted translation found |
| lk_ppn | output | 16 | Translated physical page number, 0 unless hit |
| lk_fault | output | 1 | Match found but access not permitted |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | 20 | Virtual page number being filled |
| fl_ppn | input | 16 | Physical page number being filled |
| fl_sup | input | 1 | Supervisor-only bit of the filled entry |
| fl_rd | input | 1 | Readable bit of the filled entry |
| fl_wr | input | 1 | Writable bit of the filled entry |
| fl_ex | input | 1 | Executable bit of the filled entry |

## Verification
The properties assume that `rst_n` is held low across at least one rising edge, and that every input is driven to a known value while reset is released. They also assume that lookup inputs stay stable within a cycle, because the answer is combinational. The visibility property further assumes that nothing evicts a just-filled line before the lookup in the following cycle. The bench drives all inputs on falling edges, holds fills to a single cycle, and fills only distinct tags during its sweeps, so no fill displaces a line that a later check expects.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

    // Access kind presented with a lookup
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Rights bits kept with each cached entry
    typedef struct packed {
        logic sup;
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_xlate_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int PPN_W = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [PPN_W-1:0]             wr_ppn,
    input  perm_t                        wr_perm,
    input  logic [IDX_W-1:0]             rd_set,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][PPN_W-1:0]   rd_ppn,
    output perm_t [WAYS-1:0]             rd_perm,
    input  logic [IDX_W-1:0]             fs_set,
    output logic [WAYS-1:0]              fs_valid,
    output logic [WAYS-1:0][TAG_W-1:0]   fs_tag
);

    typedef struct packed {
        logic  [SETS-1:0][WAYS-1:0]              valid;
        logic  [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag;
        logic  [SETS-1:0][WAYS-1:0][PPN_W-1:0]   ppn;
        perm_t [SETS-1:0][WAYS-1:0]              perm;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.valid = '0;
        end else if (wr_en) begin
            st_d.valid[wr_set][wr_way] = 1'b1;
            st_d.tag[wr_set][wr_way]   = wr_tag;
            st_d.ppn[wr_set][wr_way]   = wr_ppn;
            st_d.perm[wr_set][wr_way]  = wr_perm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Lookup read port and fill-side read port
    assign rd_valid = st_q.valid[rd_set];
    assign rd_tag   = st_q.tag[rd_set];
    assign rd_ppn   = st_q.ppn[rd_set];
    assign rd_perm  = st_q.perm[rd_set];
    assign fs_valid = st_q.valid[fs_set];
    assign fs_tag   = st_q.tag[fs_set];

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_xlate_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int PPN_W = 16
) (
    input  logic                         req_valid,
    input  logic [TAG_W-1:0]             req_tag,
    input  acc_e                         req_acc,
    input  logic                         req_user,
    input  logic [WAYS-1:0]              rd_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    input  logic [WAYS-1:0][PPN_W-1:0]   rd_ppn,
    input  perm_t [WAYS-1:0]             rd_perm,
    output logic [WAYS-1:0]              way_match,
    output logic                         hit,
    output logic                         fault,
    output logic [PPN_W-1:0]             ppn
);

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
        logic             any;
        logic             allowed;
        logic             deny;
    } sel_t;

    sel_t sel;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign way_match[g] = req_valid && rd_valid[g] && (rd_tag[g] == req_tag);
    end

    always_comb begin
        sel = '0;
        // at most one way matches, so an OR-merge acts as the mux
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) begin
                sel.ppn  = sel.ppn | rd_ppn[w];
                sel.perm = sel.perm | rd_perm[w];
            end
        end
        sel.any = |way_match;
        case (req_acc)
            ACC_LOAD:  sel.allowed = sel.perm.rd;
            ACC_STORE: sel.allowed = sel.perm.wr;
            ACC_FETCH: sel.allowed = sel.perm.ex;
            default:   sel.allowed = 1'b0;
        endcase
        sel.deny = (req_user && sel.perm.sup) || !sel.allowed;
    end

    assign hit   = sel.any && !sel.deny;
    assign fault = sel.any && sel.deny;
    assign ppn   = hit ? sel.ppn : '0;

endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fill_en,
    input  logic [IDX_W-1:0]             fill_set,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic [WAYS-1:0]              fs_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   fs_tag,
    output logic [WAY_W-1:0]             victim_way
);

    typedef struct packed {
        logic [SETS-1:0][WAY_W-1:0] ptr;
    } repl_t;

    typedef struct packed {
        logic             has_hit;
        logic [WAY_W-1:0] hit_way;
        logic             has_free;
        logic [WAY_W-1:0] free_way;
    } scan_t;

    repl_t st_d, st_q;
    scan_t sc;

    always_comb begin
        sc = '0;
        // descending scan leaves the lowest qualifying way
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (fs_valid[w] && (fs_tag[w] == fill_tag)) begin
                sc.has_hit = 1'b1;
                sc.hit_way = WAY_W'(w);
            end
            if (!fs_valid[w]) begin
                sc.has_free = 1'b1;
                sc.free_way = WAY_W'(w);
            end
        end

        st_d = st_q;
        if (sc.has_hit) begin
            victim_way = sc.hit_way;
        end else if (sc.has_free) begin
            victim_way = sc.free_way;
        end else begin
            victim_way = st_q.ptr[fill_set];
            if (fill_en) st_d.ptr[fill_set] = st_q.ptr[fill_set] + WAY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_xlate_pkg::*;
#(
    parameter int VPN_W    = 20,
    parameter int SET_BITS = 4,
    parameter int WAYS     = 4,
    parameter int PPN_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [1:0]        lk_acc,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_fault,
    input  logic              fl_valid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PPN_W-1:0]  fl_ppn,
    input  logic              fl_sup,
    input  logic              fl_rd,
    input  logic              fl_wr,
    input  logic              fl_ex
);

    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = VPN_W - SET_BITS;
    localparam int WAY_W = $clog2(WAYS);

    logic [SET_BITS-1:0]          lk_set, fl_set;
    logic [TAG_W-1:0]             lk_tag, fl_tag;
    logic                         fill_go;
    logic [WAY_W-1:0]             victim_way;
    perm_t                        fl_perm;
    logic [WAYS-1:0]              rd_valid, fs_valid, lk_match;
    logic [WAYS-1:0][TAG_W-1:0]   rd_tag, fs_tag;
    logic [WAYS-1:0][PPN_W-1:0]   rd_ppn;
    perm_t [WAYS-1:0]             rd_perm;

    assign lk_set  = lk_vpn[SET_BITS-1:0];
    assign lk_tag  = lk_vpn[VPN_W-1:SET_BITS];
    assign fl_set  = fl_vpn[SET_BITS-1:0];
    assign fl_tag  = fl_vpn[VPN_W-1:SET_BITS];
    assign fill_go = fl_valid && !flush;
    assign fl_perm = '{sup: fl_sup, rd: fl_rd, wr: fl_wr, ex: fl_ex};

    tlb_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (fill_go),
        .wr_set   (fl_set),
        .wr_way   (victim_way),
        .wr_tag   (fl_tag),
        .wr_ppn   (fl_ppn),
        .wr_perm  (fl_perm),
        .rd_set   (lk_set),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_ppn   (rd_ppn),
        .rd_perm  (rd_perm),
        .fs_set   (fl_set),
        .fs_valid (fs_valid),
        .fs_tag   (fs_tag)
    );

    tlb_repl #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)
    ) u_repl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_go),
        .fill_set   (fl_set),
        .fill_tag   (fl_tag),
        .fs_valid   (fs_valid),
        .fs_tag     (fs_tag),
        .victim_way (victim_way)
    );

    tlb_lookup #(
        .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)
    ) u_lookup (
        .req_valid (lk_valid),
        .req_tag   (lk_tag),
        .req_acc   (acc_e'(lk_acc)),
        .req_user  (lk_user),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_ppn    (rd_ppn),
        .rd_perm   (rd_perm),
        .way_match (lk_match),
        .hit       (lk_hit),
        .fault     (lk_fault),
        .ppn       (lk_ppn)
    );

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 16,
    parameter int WAYS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [1:0]        lk_acc,
    input logic              lk_user,
    input logic              lk_hit,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic              lk_fault,
    input logic              fl_valid,
    input logic [VPN_W-1:0]  fl_vpn,
    input logic              fl_rd,
    input logic [WAYS-1:0]   lk_match
);

    assert_hit_fault_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));

    assert_miss_zero_ppn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0));

    assert_no_duplicate_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_hit && !lk_fault));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_fault && lk_ppn == '0));

    assert_fill_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fl_valid) && !$past(flush) && $past(fl_rd) &&
         lk_valid && lk_vpn == $past(fl_vpn) && !lk_user && lk_acc == 2'd0)
        |-> lk_hit);

endmodule

bind tlb_xlate tlb_xlate_chk #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .WAYS(WAYS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_valid (lk_valid),
    .lk_vpn   (lk_vpn),
    .lk_acc   (lk_acc),
    .lk_user  (lk_user),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .lk_fault (lk_fault),
    .fl_valid (fl_valid),
    .fl_vpn   (fl_vpn),
    .fl_rd    (fl_rd),
    .lk_match (lk_match)
);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_user = 1'b0;
    logic        lk_hit, lk_fault;
    logic [15:0] lk_ppn;
    logic        fl_valid = 1'b0;
    logic [19:0] fl_vpn = '0;
    logic [15:0] fl_ppn = '0;
    logic        fl_sup = 1'b0, fl_rd = 1'b0, fl_wr = 1'b0, fl_ex = 1'b0;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    tlb_xlate dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_fault(lk_fault),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
        .fl_sup(fl_sup), .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_ex(fl_ex)
    );

    function automatic logic [15:0] tag_of(int s, int w);
        return {4'(w), 8'(s * 3 + 1), 4'hA};
    endfunction

    function automatic logic [15:0] ppn_of(int s, int w);
        return 16'(s * 256 + w * 17 + 5);
    endfunction

    // perm nibble = {sup, rd, wr, ex}
    function automatic logic [3:0] perm_of(int s, int w);
        return 4'(s + w * 5);
    endfunction

    task automatic expect_out(string req, logic eh, logic [15:0] ep, logic ef);
        n_chk++;
        if (lk_hit !== eh || lk_ppn !== ep || lk_fault !== ef) begin
            n_err++;
            $display("FAIL %s: vpn=%h acc=%0d user=%0b got hit=%0b ppn=%h fault=%0b exp hit=%0b ppn=%h fault=%0b",
                     req, lk_vpn, lk_acc, lk_user, lk_hit, lk_ppn, lk_fault, eh, ep, ef);
        end
    endtask

    task automatic look(string req, logic [19:0] vpn, logic [1:0] acc, logic user,
                        logic eh, logic [15:0] ep, logic ef);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn; lk_acc = acc; lk_user = user;
        #1;
        expect_out(req, eh, ep, ef);
    endtask

    task automatic fill(logic [19:0] vpn, logic [15:0] ppn, logic [3:0] perm, logic with_flush);
        @(negedge clk);
        fl_valid = 1'b1; fl_vpn = vpn; fl_ppn = ppn;
        {fl_sup, fl_rd, fl_wr, fl_ex} = perm;
        flush = with_flush;
        @(negedge clk);
        fl_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    function automatic logic [19:0] set5(int k);
        return {16'(16'hC000 + k), 4'd5};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: empty after reset
        look("R10", {tag_of(0, 0), 4'd0}, 2'd0, 1'b0, 1'b0, 16'h0, 1'b0);
        look("R10", {tag_of(9, 2), 4'd9}, 2'd0, 1'b0, 1'b0, 16'h0, 1'b0);

        // fill every way of every set with distinct tags
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                fill({tag_of(s, w), 4'(s)}, ppn_of(s, w), perm_of(s, w), 1'b0);

        // R1 R2 R3: sweep all lines, access kinds and modes
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                for (int a = 0; a < 4; a++)
                    for (int u = 0; u < 2; u++) begin
                        logic [3:0] p;
                        logic ok, deny;
                        p = perm_of(s, w);
                        ok = (a == 0) ? p[2] : (a == 1) ? p[1] : (a == 2) ? p[0] : 1'b0;
                        deny = (u == 1 && p[3]) || !ok;
                        look("R3", {tag_of(s, w), 4'(s)}, 2'(a), 1'(u),
                             !deny, deny ? 16'h0 : ppn_of(s, w), deny);
                    end

        // R1: absent tags in every set miss
        for (int s = 0; s < 16; s++)
            look("R1", {tag_of(s, 6), 4'(s)}, 2'd0, 1'b0, 1'b0, 16'h0, 1'b0);
        // R1: right tag, wrong set misses (set 3 has tag_of(2,0)? no)
        look("R1", {tag_of(2, 0), 4'd3}, 2'd0, 1'b0, 1'b0, 16'h0, 1'b0);

        // R9: idle lookup on a present permitted line
        @(negedge clk);
        lk_valid = 1'b0; lk_vpn = {tag_of(1, 1), 4'd1}; lk_acc = 2'd0; lk_user = 1'b0;
        #1;
        expect_out("R9", 1'b0, 16'h0, 1'b0);

        // R7: flush empties everything
        do_flush();
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                look("R7", {tag_of(s, w), 4'(s)}, 2'd0, 1'b0, 1'b0, 16'h0, 1'b0);

        // R7: fill alongside flush is dropped
        fill(set5(50), 16'h5050, 4'b0111, 1'b1);
        look("R7", set5(50), 2'd0, 1'b0, 1'b0, 16'h0, 1'b0);

        // R8: fill not visible in its own cycle, visible after the edge
        @(negedge clk);
        fl_valid = 1'b1; fl_vpn = {16'h7777, 4'd8}; fl_ppn = 16'h0888;
        {fl_sup, fl_rd, fl_wr, fl_ex} = 4'b0111;
        lk_valid = 1'b1; lk_vpn = {16'h7777, 4'd8}; lk_acc = 2'd0; lk_user = 1'b0;
        #1;
        expect_out("R8", 1'b0, 16'h0, 1'b0);
        @(negedge clk);
        fl_valid = 1'b0;
        #1;
        expect_out("R8", 1'b1, 16'h0888, 1'b0);

        // R4 R5: replacement order in set 5 (pointer still at way 0)
        for (int k = 0; k < 4; k++) fill(set5(k), 16'(16'h0100 + k), 4'b0111, 1'b0);
        fill(set5(4), 16'h0104, 4'b0111, 1'b0);          // evicts way 0 (k=0)
        look("R5", set5(0), 2'd0, 1'b0, 1'b0, 16'h0, 1'b0);
        for (int k = 1; k < 5; k++)
            look("R4", set5(k), 2'd0, 1'b0, 1'b1, 16'(16'h0100 + k), 1'b0);
        fill(set5(5), 16'h0105, 4'b0111, 1'b0);          // evicts way 1 (k=1)
        look("R5", set5(1), 2'd0, 1'b0, 1'b0, 16'h0, 1'b0);
        look("R5", set5(5), 2'd0, 1'b0, 1'b1, 16'h0105, 1'b0);

        // R6: refill present tag k=2 (way 2) with a new ppn
        fill(set5(2), 16'h0AAA, 4'b0111, 1'b0);
        look("R6", set5(2), 2'd0, 1'b0, 1'b1, 16'h0AAA, 1'b0);
        for (int k = 3; k < 6; k++)
            look("R6", set5(k), 2'd0, 1'b0, 1'b1, 16'(16'h0100 + k), 1'b0);
        // pointer untouched: next eviction takes way 2 (k=2)
        fill(set5(6), 16'h0106, 4'b0111, 1'b0);
        look("R6", set5(2), 2'd0, 1'b0, 1'b0, 16'h0, 1'b0);
        for (int k = 3; k < 7; k++)
            look("R5", set5(k), 2'd0, 1'b0, 1'b1, 16'(16'h0100 + k), 1'b0);

        // R3: reserved access code faults even with all rights
        look("R3", set5(3), 2'd3, 1'b0, 1'b0, 16'h0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule